// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small RISC datapath. It takes two operands, a carry input and a five-bit operation select. It produces the result combinationally in the same cycle. It also keeps an eight-bit status byte that is rewritten on a clock edge only when the commit enable is high.

Every operation owns a fixed set of flags. Only those flags are rewritten on a commit, and every other status bit keeps its stored value. The signed-test flag is always written as the exclusive OR of the negative and overflow flags. A branch unit outside the block can therefore test a signed comparison with one bit.

The register file, the choice of operands, branching, interrupts and multiplication all sit outside the block. The block does not feed the stored carry back to itself: the datapath routes the carry into `carry_in` for the through-carry operations.

Top module: `flag_alu`

## Requirements
- R1: Opcodes 0 and 1 compute A+B and A+B+carry_in, modulo 256. They rewrite H (carry out of bit 3), V (signed overflow), N (result bit 7), Z (result zero), C (carry out of bit 7) and S.
- R2: Opcodes 2 and 3 compute A-B and A-B-carry_in. Opcode 8 computes 0x00-A. C is the borrow out of bit 7 and H is the borrow out of bit 3. V, N, Z and S are also rewritten.
- R3: Opcodes 4, 5 and 6 (AND, OR, XOR) clear V and update N, Z and S. C and H keep their stored values.
- R4: Opcode 7 returns 0xFF-A. It sets C to 1, clears V, updates N, Z and S, and keeps H.
- R5: Opcodes 9 and 10 return A+1 and A-1. V is set only for 0x7F to 0x80 on an increment and only for 0x80 to 0x7F on a decrement. N, Z and S are updated, and C and H keep their stored values.
- R6: Opcode 11 shifts left with a 0 into bit 0. Opcode 12 shifts right with a 0 into bit 7. Opcode 15 shifts right and keeps bit 7. In each case C takes the bit shifted out, V becomes N xor C, and N, Z and S are updated.
- R7: Opcode 13 rotates left, with carry_in entering bit 0 and bit 7 going to C. Opcode 14 rotates right, with carry_in entering bit 7 and bit 0 going to C. Their flags follow the same rules as R6.
- R8: Opcode 16 exchanges the upper and lower nibbles of A and leaves the whole status byte unchanged.
- R9: In the stored status, S always equals N xor V.
- R10: Reset clears the status to 0x00. The status changes only on a clock edge where flag_we is high. Bits 7 and 6 are never altered by an operation.
- R11: Opcodes 17 to 31 return 0x00 and leave the status unchanged.
- R12: The status bit positions from bit 7 down to bit 0 are I, T, H, S, V, N, Z, C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand |
| carry_in | input | 1 | Carry used by add-with-carry, subtract-with-carry and the rotates |
| op_sel | input | 5 | Operation select, encoded as in R1 to R11 |
| flag_we | input | 1 | Commit enable for the status byte |
| result | output | 8 | Combinational result of the selected operation |
| status | output | 8 | Stored status byte, laid out as in R12 |

## Verification
`result` is combinational, so it is due in the same cycle the inputs change. The bench drives the inputs on a falling edge and samples `result` a nanosecond later. The new `status` is due after exactly one rising edge that has `flag_we` high. The bench samples it on the next falling edge, before it drives the next vector. Each vector's expected status therefore builds on the one committed before it, which lets the checks see that kept flags really are kept. A cycle with `flag_we` low is checked at that same falling edge to confirm that nothing moved.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

   typedef enum logic [4:0] {
      OP_ADD  = 5'd0,
      OP_ADC  = 5'd1,
      OP_SUB  = 5'd2,
      OP_SBC  = 5'd3,
      OP_AND  = 5'd4,
      OP_OR   = 5'd5,
      OP_XOR  = 5'd6,
      OP_COM  = 5'd7,
      OP_NEG  = 5'd8,
      OP_INC  = 5'd9,
      OP_DEC  = 5'd10,
      OP_LSL  = 5'd11,
      OP_LSR  = 5'd12,
      OP_ROL  = 5'd13,
      OP_ROR  = 5'd14,
      OP_ASR  = 5'd15,
      OP_SWAP = 5'd16
   } alu_op_e;

   // status byte bit positions (R12)
   localparam int unsigned SB_C = 0;
   localparam int unsigned SB_Z = 1;
   localparam int unsigned SB_N = 2;
   localparam int unsigned SB_V = 3;
   localparam int unsigned SB_S = 4;
   localparam int unsigned SB_H = 5;
   localparam int unsigned SB_T = 6;
   localparam int unsigned SB_I = 7;

   localparam logic [7:0] MSK_H = 8'h20;
   localparam logic [7:0] MSK_S = 8'h10;
   localparam logic [7:0] MSK_V = 8'h08;
   localparam logic [7:0] MSK_N = 8'h04;
   localparam logic [7:0] MSK_Z = 8'h02;
   localparam logic [7:0] MSK_C = 8'h01;

   // which status bits an operation rewrites
   function automatic logic [7:0] flag_mask(input logic [4:0] op);
      logic [7:0] m;
      case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG:
            m = MSK_H | MSK_S | MSK_V | MSK_N | MSK_Z | MSK_C;
         OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC:
            m = MSK_S | MSK_V | MSK_N | MSK_Z;
         OP_COM, OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR:
            m = MSK_S | MSK_V | MSK_N | MSK_Z | MSK_C;
         default:
            m = 8'h00;
      endcase
      return m;
   endfunction

   function automatic logic is_arith(input logic [4:0] op);
      return (op <= OP_SBC) || (op == OP_NEG) || (op == OP_INC) || (op == OP_DEC);
   endfunction

endpackage

// File: rtl/flag_alu_addsub.sv
module flag_alu_addsub #(
   parameter int unsigned DATA_W = 8,
   parameter bit          RIPPLE = 1'b0
) (
   input  logic [DATA_W-1:0] x,
   input  logic [DATA_W-1:0] y,
   input  logic              c_in,   // carry (add) or borrow (sub) into bit 0
   input  logic              sub,
   output logic [DATA_W-1:0] sum,
   output logic              c_out,  // carry or borrow out of the top bit
   output logic              h_out,  // carry or borrow out of the half point
   output logic              ovf
);
   localparam int unsigned HALF_W = DATA_W / 2;

   logic [DATA_W-1:0] y_eff;
   logic              c0;
   logic              raw_co;
   logic              raw_hc;
   logic              raw_msb;

   assign y_eff = sub ? ~y : y;
   assign c0    = sub ? ~c_in : c_in;

   generate
      if (RIPPLE) begin : g_ripple
         logic [DATA_W:0] cc;
         assign cc[0] = c0;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign sum[i]  = x[i] ^ y_eff[i] ^ cc[i];
            assign cc[i+1] = (x[i] & y_eff[i]) | (cc[i] & (x[i] ^ y_eff[i]));
         end
         assign raw_co  = cc[DATA_W];
         assign raw_hc  = cc[HALF_W];
         assign raw_msb = cc[DATA_W-1];
      end else begin : g_flat
         logic [DATA_W:0]   full;
         logic [HALF_W:0]   lo;
         logic [DATA_W-1:0] low_msb;
         assign full    = {1'b0, x} + {1'b0, y_eff} + {{DATA_W{1'b0}}, c0};
         assign lo      = {1'b0, x[HALF_W-1:0]} + {1'b0, y_eff[HALF_W-1:0]}
                        + {{HALF_W{1'b0}}, c0};
         assign low_msb = {1'b0, x[DATA_W-2:0]} + {1'b0, y_eff[DATA_W-2:0]}
                        + {{(DATA_W-1){1'b0}}, c0};
         assign sum     = full[DATA_W-1:0];
         assign raw_co  = full[DATA_W];
         assign raw_hc  = lo[HALF_W];
         assign raw_msb = low_msb[DATA_W-1];
      end
   endgenerate

   assign c_out = sub ? ~raw_co : raw_co;
   assign h_out = sub ? ~raw_hc : raw_hc;
   assign ovf   = raw_msb ^ raw_co;

endmodule

// File: rtl/flag_alu_bitops.sv
module flag_alu_bitops
   import flag_alu_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic [4:0]        op,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              c_in,
   output logic [DATA_W-1:0] res,
   output logic              sh_c
);
   localparam int unsigned HALF_W = DATA_W / 2;

   always_comb begin
      res  = '0;
      sh_c = 1'b0;
      case (op)
         OP_AND:  res = a & b;
         OP_OR:   res = a | b;
         OP_XOR:  res = a ^ b;
         OP_COM:  res = ~a;
         OP_LSL: begin
            res  = {a[DATA_W-2:0], 1'b0};
            sh_c = a[DATA_W-1];
         end
         OP_LSR: begin
            res  = {1'b0, a[DATA_W-1:1]};
            sh_c = a[0];
         end
         OP_ROL: begin
            res  = {a[DATA_W-2:0], c_in};
            sh_c = a[DATA_W-1];
         end
         OP_ROR: begin
            res  = {c_in, a[DATA_W-1:1]};
            sh_c = a[0];
         end
         OP_ASR: begin
            res  = {a[DATA_W-1], a[DATA_W-1:1]};
            sh_c = a[0];
         end
         OP_SWAP: res = {a[HALF_W-1:0], a[DATA_W-1:HALF_W]};
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/flag_alu_flags.sv
module flag_alu_flags
   import flag_alu_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic [4:0]        op,
   input  logic [7:0]        cur,
   input  logic [DATA_W-1:0] res,
   input  logic              ar_c,
   input  logic              ar_h,
   input  logic              ar_v,
   input  logic              sh_c,
   output logic [7:0]        nxt
);
   logic [7:0] fresh;
   logic [7:0] mask;
   logic       f_n;
   logic       f_z;
   logic       f_v;
   logic       f_c;
   logic       f_h;

   assign f_n  = res[DATA_W-1];
   assign f_z  = (res == '0);
   assign mask = flag_mask(op);

   always_comb begin
      f_v = 1'b0;
      f_c = cur[SB_C];
      f_h = cur[SB_H];
      case (op)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
            f_v = ar_v;
            f_c = ar_c;
            f_h = ar_h;
         end
         OP_INC, OP_DEC: f_v = ar_v;
         OP_COM:         f_c = 1'b1;
         OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
            f_c = sh_c;
            f_v = f_n ^ sh_c;
         end
         default: f_v = 1'b0;
      endcase
      fresh        = cur;
      fresh[SB_H]  = f_h;
      fresh[SB_S]  = f_n ^ f_v;
      fresh[SB_V]  = f_v;
      fresh[SB_N]  = f_n;
      fresh[SB_Z]  = f_z;
      fresh[SB_C]  = f_c;
      nxt          = (cur & ~mask) | (fresh & mask);
   end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
   import flag_alu_pkg::*;
#(
   parameter int unsigned DATA_W       = 8,
   parameter bit          RIPPLE       = 1'b0,
   parameter logic [7:0]  RESET_STATUS = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic              carry_in,
   input  logic [4:0]        op_sel,
   input  logic              flag_we,
   output logic [DATA_W-1:0] result,
   output logic [7:0]        status
);
   localparam int unsigned HALF_W = DATA_W / 2;

   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("flag_alu: DATA_W must be even and at least 4");
      end
      if (HALF_W * 2 != DATA_W) begin : g_bad_half
         $error("flag_alu: half width does not divide data width");
      end
   endgenerate

   logic [DATA_W-1:0] ax;
   logic [DATA_W-1:0] ay;
   logic              acin;
   logic              asub;
   logic [DATA_W-1:0] asum;
   logic              ac;
   logic              ah;
   logic              av;
   logic [DATA_W-1:0] bres;
   logic              bc;
   logic [7:0]        status_d;
   logic [7:0]        status_q;

   // operand steering into the shared adder
   always_comb begin
      ax   = opnd_a;
      ay   = opnd_b;
      acin = 1'b0;
      asub = 1'b0;
      case (op_sel)
         OP_ADC: acin = carry_in;
         OP_SUB: asub = 1'b1;
         OP_SBC: begin
            asub = 1'b1;
            acin = carry_in;
         end
         OP_NEG: begin
            ax   = '0;
            ay   = opnd_a;
            asub = 1'b1;
         end
         OP_INC: begin
            ay   = '0;
            acin = 1'b1;
         end
         OP_DEC: begin
            ay   = '0;
            acin = 1'b1;
            asub = 1'b1;
         end
         default: acin = 1'b0;
      endcase
   end

   flag_alu_addsub #(.DATA_W(DATA_W), .RIPPLE(RIPPLE)) u_addsub (
      .x     (ax),
      .y     (ay),
      .c_in  (acin),
      .sub   (asub),
      .sum   (asum),
      .c_out (ac),
      .h_out (ah),
      .ovf   (av)
   );

   flag_alu_bitops #(.DATA_W(DATA_W)) u_bitops (
      .op   (op_sel),
      .a    (opnd_a),
      .b    (opnd_b),
      .c_in (carry_in),
      .res  (bres),
      .sh_c (bc)
   );

   assign result = is_arith(op_sel) ? asum : bres;

   flag_alu_flags #(.DATA_W(DATA_W)) u_flags (
      .op   (op_sel),
      .cur  (status_q),
      .res  (result),
      .ar_c (ac),
      .ar_h (ah),
      .ar_v (av),
      .sh_c (bc),
      .nxt  (status_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       status_q <= RESET_STATUS;
      else if (flag_we) status_q <= status_d;
   end

   assign status = status_q;

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk
   import flag_alu_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [4:0]        op_sel,
   input logic              flag_we,
   input logic [DATA_W-1:0] result,
   input logic [7:0]        status
);
   logic is_logic;
   logic is_incdec;
   logic writes_z;

   assign is_logic  = (op_sel == OP_AND) || (op_sel == OP_OR) || (op_sel == OP_XOR);
   assign is_incdec = (op_sel == OP_INC) || (op_sel == OP_DEC);
   assign writes_z  = (op_sel <= OP_ASR);

   AST_HOLD_WITHOUT_WE: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_we |=> $stable(status)); // R10

   AST_IT_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(status[7:6])); // R10

   AST_S_IS_N_XOR_V: assert property (@(posedge clk) disable iff (!rst_n)
      status[SB_S] == (status[SB_N] ^ status[SB_V])); // R9

   AST_SWAP_KEEPS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && op_sel == OP_SWAP) |=> $stable(status)); // R8

   AST_LOGIC_KEEPS_CH: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && is_logic) |=> (status[SB_C] == $past(status[SB_C]))
                                && (status[SB_H] == $past(status[SB_H]))
                                && !status[SB_V]); // R3

   AST_INCDEC_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && is_incdec) |=> $stable(status[SB_C])); // R5

   AST_Z_FOLLOWS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && writes_z) |=> status[SB_Z] == ($past(result) == '0)); // R12

   AST_UNDEF_OP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel > OP_SWAP) |-> result == '0); // R11

   AST_UNDEF_OP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && op_sel > OP_SWAP) |=> $stable(status)); // R11

endmodule

bind flag_alu flag_alu_chk #(.DATA_W(DATA_W)) u_flag_alu_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .op_sel  (op_sel),
   .flag_we (flag_we),
   .result  (result),
   .status  (status)
);

// File: tb/flag_alu_test.sv
module flag_alu_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] a = 8'h00;
   logic [7:0] b = 8'h00;
   logic       cin = 1'b0;
   logic [4:0] op = 5'd0;
   logic       we = 1'b0;
   logic [7:0] res;
   logic [7:0] st;
   int         checks = 0;
   int         errors = 0;

   always #4 clk = ~clk;

   flag_alu uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .opnd_a   (a),
      .opnd_b   (b),
      .carry_in (cin),
      .op_sel   (op),
      .flag_we  (we),
      .result   (res),
      .status   (st)
   );

   // {req, op, a, b, carry_in, expected result, expected status}
   // status bits: H=20 S=10 V=08 N=04 Z=02 C=01; the chain starts at 0x00
   localparam int NV = 24;
   localparam logic [41:0] VEC [NV] = '{
      {4'd1,  5'd0,  8'h3A, 8'h08, 1'b0, 8'h42, 8'h20}, // R1 half carry
      {4'd1,  5'd0,  8'h7F, 8'h01, 1'b0, 8'h80, 8'h2C}, // R1 overflow
      {4'd1,  5'd1,  8'hFF, 8'h00, 1'b1, 8'h00, 8'h23}, // R1 carry in
      {4'd2,  5'd2,  8'h10, 8'h01, 1'b0, 8'h0F, 8'h20}, // R2 half borrow
      {4'd2,  5'd3,  8'h80, 8'h01, 1'b1, 8'h7E, 8'h38}, // R2 overflow, S
      {4'd2,  5'd2,  8'h05, 8'h07, 1'b0, 8'hFE, 8'h35}, // R2 borrow
      {4'd3,  5'd4,  8'hF0, 8'h0F, 1'b0, 8'h00, 8'h23}, // R3 AND keeps C,H
      {4'd3,  5'd5,  8'h40, 8'h81, 1'b0, 8'hC1, 8'h35}, // R3 OR
      {4'd3,  5'd6,  8'h55, 8'h55, 1'b0, 8'h00, 8'h23}, // R3 XOR
      {4'd4,  5'd7,  8'h0F, 8'h00, 1'b0, 8'hF0, 8'h35}, // R4 COM
      {4'd2,  5'd8,  8'h80, 8'h00, 1'b0, 8'h80, 8'h0D}, // R2 NEG 0x80
      {4'd2,  5'd8,  8'h00, 8'h00, 1'b0, 8'h00, 8'h02}, // R2 NEG zero
      {4'd5,  5'd9,  8'h7F, 8'h00, 1'b1, 8'h80, 8'h0C}, // R5 INC overflow
      {4'd5,  5'd10, 8'h80, 8'h00, 1'b1, 8'h7F, 8'h18}, // R5 DEC overflow
      {4'd1,  5'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 8'h23}, // R1 wrap
      {4'd5,  5'd10, 8'h01, 8'h00, 1'b0, 8'h00, 8'h23}, // R5 DEC keeps C=1
      {4'd6,  5'd11, 8'h81, 8'h00, 1'b0, 8'h02, 8'h39}, // R6 LSL
      {4'd6,  5'd12, 8'h80, 8'h00, 1'b1, 8'h40, 8'h20}, // R6 LSR
      {4'd6,  5'd15, 8'h81, 8'h00, 1'b0, 8'hC0, 8'h35}, // R6 ASR
      {4'd7,  5'd13, 8'h80, 8'h00, 1'b1, 8'h01, 8'h39}, // R7 ROL
      {4'd7,  5'd14, 8'h01, 8'h00, 1'b0, 8'h00, 8'h3B}, // R7 ROR zero
      {4'd7,  5'd14, 8'h02, 8'h00, 1'b1, 8'h81, 8'h2C}, // R7 ROR carry in
      {4'd8,  5'd16, 8'hA5, 8'h00, 1'b1, 8'h5A, 8'h2C}, // R8 SWAP
      {4'd11, 5'd31, 8'hA5, 8'h5A, 1'b1, 8'h00, 8'h2C}  // R11 undefined
   };

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [3:0] rq;
      logic [4:0] vo;
      logic [7:0] va;
      logic [7:0] vb;
      logic       vc;
      logic [7:0] er;
      logic [7:0] es;

      repeat (3) @(negedge clk);
      check("R10 reset status", st, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 status after reset release", st, 8'h00);

      for (int i = 0; i < NV; i++) begin
         {rq, vo, va, vb, vc, er, es} = VEC[i];
         op = vo; a = va; b = vb; cin = vc; we = 1'b1;
         #1;
         check($sformatf("R%0d result vec %0d", rq, i), res, er);
         @(negedge clk);
         check($sformatf("R%0d status vec %0d", rq, i), st, es);
      end

      // R10: no commit without flag_we; status stays 0x2C
      op = 5'd0; a = 8'hFF; b = 8'h01; cin = 1'b0; we = 1'b0;
      #1;
      check("R1 result with we low", res, 8'h00);
      @(negedge clk);
      check("R10 status held with we low", st, 8'h2C);
      @(negedge clk);
      check("R10 status still held", st, 8'h2C);

      // same operation committed
      we = 1'b1;
      @(negedge clk);
      check("R1 status after commit", st, 8'h23);

      // R11: another undefined code
      op = 5'd20; a = 8'h7F; b = 8'h80;
      #1;
      check("R11 undefined result", res, 8'h00);
      @(negedge clk);
      check("R11 undefined keeps status", st, 8'h23);

      // R8: swap with all flags set-able bits at 0x23
      op = 5'd16; a = 8'h3C;
      #1;
      check("R8 swap result", res, 8'hC3);
      @(negedge clk);
      check("R8 swap keeps status", st, 8'h23);

      // R10: asynchronous reset in the middle of a run
      we = 1'b0;
      rst_n = 1'b0;
      #1;
      check("R10 status cleared by reset", st, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 I/T bits stay zero", st & 8'hC0, 8'h00);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule